// File: doc/BRIEF.md
# Candidate Offset Pool Manager

This block keeps a pool of sixteen candidate prefetch offsets and the last accuracy score that each one earned. An external evaluator takes one candidate at a time. The pool presents the current slot and its offset. When the evaluator raises `eval_done`, the pool stores the score it reports into that slot and moves on to the next slot in round-robin order.

When the sixteenth evaluation of a round completes, the pool stops accepting results for a few cycles. In that window it retires the four lowest-scoring candidates. It fills each freed slot with an offset in the range -16..+16, zero excluded, that has not been tried recently. All sixteen offset and score pairs are always visible on flat read buses for the issue logic.

Each offset is held in a 5-bit code. Bit 4 set means the offset is negative. Bits 3:0 hold the magnitude minus one. The code therefore covers exactly the thirty-two legal offsets and cannot express zero.

Top module: `offset_pool`

## Requirements
- R1: After reset the slot pointer is 0, `eval_ready` is 1, and every score is 0. Slot i for i<8 holds offset -(8-i), which is code 16+(7-i). Slot i for i>=8 holds offset +(i-7), which is code i-8.
- R2: Offsets use the 5-bit code defined above: bit 4 is the sign (1 means negative), and bits 3:0 are the magnitude minus one. `eval_offset` always equals the code stored in slot `eval_slot`.
- R3: When `eval_done` is high and `eval_ready` is high at a clock edge, the score is written into the current slot and the slot pointer advances by one, wrapping from 15 to 0. When `eval_done` is high while `eval_ready` is low, nothing changes: no score is written and the pointer does not move.
- R4: Accepting the result for slot 15 drops `eval_ready` on the next cycle. It stays low for 4 cycles, or 5 cycles if the recent-use record has to be cleared during that window.
- R5: Each replacement step removes the unreplaced slot with the lowest score. Ties go to the lower slot index. Four slots are replaced per round. The other twelve slots keep their offsets and scores, and no offset changes while `eval_ready` is high.
- R6: Each refilled slot receives the lowest code that is not marked as recently used, and its score is set to 0.
- R7: A 32-bit recent-use record marks every code that has been inserted since the last clear, together with the initial pool codes. When all 32 bits are set, one step is spent clearing the record down to just the codes currently in the pool.
- R8: The sixteen offsets in the pool are always distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_done | input | 1 | Evaluator has finished the current candidate |
| eval_score | input | 10 | Accuracy score for the current candidate |
| eval_ready | output | 1 | Pool accepts a result (low during replacement) |
| eval_slot | output | 4 | Slot currently under evaluation |
| eval_offset | output | 5 | Offset code of the current slot |
| pool_offsets | output | 80 | All offset codes, slot i at bits [5i+4:5i] |
| pool_scores | output | 160 | All scores, slot i at bits [10i+9:10i] |

## Verification
The assertions assume that `eval_done` reflects the evaluator's view of the slot shown in the same cycle. They place no limit on the score value, and they allow `eval_done` to be raised at any time, including during replacement. The stimulus deliberately holds `eval_done` high with a maximal score through every replacement window, so that the stall path is exercised. It also mixes random scores with idle gaps, uses all-equal and strictly descending score rounds to pin down the tie-breaking and victim order, and runs enough rounds for the recent-use record to fill up and clear.

// File: rtl/offset_pool.sv
module offset_pool #(
  parameter int SLOTS = 16,
  parameter int OFFW  = 5,
  parameter int SCW   = 10,
  parameter int NREPL = 4,
  localparam int SLW  = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  eval_done,
  input  logic [SCW-1:0]        eval_score,
  output logic                  eval_ready,
  output logic [SLW-1:0]        eval_slot,
  output logic [OFFW-1:0]       eval_offset,
  output logic [SLOTS*OFFW-1:0] pool_offsets,
  output logic [SLOTS*SCW-1:0]  pool_scores
);

  localparam int CODES = 1 << OFFW;
  localparam int KW    = (NREPL > 1) ? $clog2(NREPL) : 1;

  logic [OFFW-1:0]  offs [SLOTS];
  logic [SCW-1:0]   scs  [SLOTS];
  logic [CODES-1:0] used, inpool;
  logic [SLOTS-1:0] taken;
  logic [SLW-1:0]   cur, vic;
  logic [OFFW-1:0]  fcode;
  logic [KW-1:0]    step;
  logic             busy;

  function automatic logic [OFFW-1:0] init_code(int i);
    if (i < SLOTS/2) return {1'b1, (OFFW-1)'(SLOTS/2 - 1 - i)};
    else             return {1'b0, (OFFW-1)'(i - SLOTS/2)};
  endfunction

  always_comb begin
    inpool = '0;
    for (int i = 0; i < SLOTS; i++) inpool[offs[i]] = 1'b1;
  end

  always_comb begin
    logic            hit;
    logic [SCW-1:0]  best;
    hit  = 1'b0;
    best = '1;
    vic  = '0;
    for (int i = 0; i < SLOTS; i++)
      if (!taken[i] && (!hit || scs[i] < best)) begin
        hit  = 1'b1;
        best = scs[i];
        vic  = SLW'(i);
      end
  end

  always_comb begin
    logic hit;
    hit   = 1'b0;
    fcode = '0;
    for (int c = 0; c < CODES; c++)
      if (!used[c] && !hit) begin
        hit   = 1'b1;
        fcode = OFFW'(c);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used  <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        offs[i] <= init_code(i);
        scs[i]  <= '0;
        used[init_code(i)] <= 1'b1;
      end
      cur   <= '0;
      busy  <= 1'b0;
      step  <= '0;
      taken <= '0;
    end else if (busy) begin
      if (&used) begin
        used <= inpool;
      end else begin
        offs[vic]   <= fcode;
        scs[vic]    <= '0;
        used[fcode] <= 1'b1;
        taken[vic]  <= 1'b1;
        step        <= step + 1'b1;
        if (step == KW'(NREPL - 1)) busy <= 1'b0;
      end
    end else if (eval_done) begin
      scs[cur] <= eval_score;
      cur      <= cur + 1'b1;
      if (cur == SLW'(SLOTS - 1)) begin
        busy  <= 1'b1;
        step  <= '0;
        taken <= '0;
      end
    end
  end

  assign eval_ready  = !busy;
  assign eval_slot   = cur;
  assign eval_offset = offs[cur];

  for (genvar g = 0; g < SLOTS; g++) begin : g_flat
    assign pool_offsets[g*OFFW +: OFFW] = offs[g];
    assign pool_scores[g*SCW +: SCW]    = scs[g];
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_done && eval_ready) |=> eval_slot == SLW'($past(eval_slot) + 1'b1)); // R3
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(eval_done && eval_ready) |=> $stable(eval_slot)); // R3
  AST_SCORES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_ready && !eval_done) |=> $stable(pool_scores)); // R3
  AST_STALL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_done && eval_ready && eval_slot == SLW'(SLOTS - 1)) |=> !eval_ready); // R4
  AST_OFFS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    eval_ready |=> $stable(pool_offsets)); // R5
  AST_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(inpool) == SLOTS); // R8
  AST_OFFSET_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    eval_offset == pool_offsets[eval_slot*OFFW +: OFFW]); // R2

endmodule

// File: tb/sim_offset_pool.sv
module sim_offset_pool;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         eval_done = 1'b0;
  logic [9:0]   eval_score = '0;
  logic         eval_ready;
  logic [3:0]   eval_slot;
  logic [4:0]   eval_offset;
  logic [79:0]  pool_offsets;
  logic [159:0] pool_scores;

  int errors = 0;
  int checks = 0;
  bit ended = 0;
  int moff [16];
  int msc  [16];
  bit mused [32];
  int eslot = 0;

  always #2 clk = ~clk;

  offset_pool u0 (.clk(clk), .rst_n(rst_n), .eval_done(eval_done), .eval_score(eval_score),
    .eval_ready(eval_ready), .eval_slot(eval_slot), .eval_offset(eval_offset),
    .pool_offsets(pool_offsets), .pool_scores(pool_scores));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int first_free();
    for (int c = 0; c < 32; c++) if (!mused[c]) return c;
    return -1;
  endfunction

  function automatic int model_repl();
    bit taken [16];
    int cyc = 0;
    int k = 0;
    for (int i = 0; i < 16; i++) taken[i] = 0;
    while (k < 4) begin
      bit full = 1;
      cyc++;
      for (int c = 0; c < 32; c++) if (!mused[c]) full = 0;
      if (full) begin
        for (int c = 0; c < 32; c++) mused[c] = 0;
        for (int i = 0; i < 16; i++) mused[moff[i]] = 1;
      end else begin
        int v = -1;
        int f = first_free();
        for (int i = 0; i < 16; i++)
          if (!taken[i] && (v < 0 || msc[i] < msc[v])) v = i;
        moff[v] = f;
        msc[v] = 0;
        mused[f] = 1;
        taken[v] = 1;
        k++;
      end
    end
    return cyc;
  endfunction

  task automatic check_pool(input string tag);
    for (int i = 0; i < 16; i++) begin
      chk({tag, " offset"}, int'(pool_offsets[i*5 +: 5]), moff[i]);
      chk({tag, " score"}, int'(pool_scores[i*10 +: 10]), msc[i]);
    end
  endtask

  task automatic do_eval(input int s);
    eval_done = 1'b1;
    eval_score = 10'(s);
    @(negedge clk);
    eval_done = 1'b0;
    msc[eslot] = s;
    chk("R3 stored score", int'(pool_scores[eslot*10 +: 10]), s);
    eslot = (eslot + 1) % 16;
    chk("R3 slot advance", int'(eval_slot), eslot);
    chk("R2 current offset", int'(eval_offset), moff[eslot]);
  endtask

  task automatic run_round(input int mode);
    for (int j = 0; j < 16; j++) begin
      int s;
      case (mode)
        0: s = 100;
        1: s = 1000 - j * 50;
        default: s = int'($urandom % 1024);
      endcase
      if (mode > 1 && ($urandom % 4) == 0) begin
        @(negedge clk);
        chk("R3 idle slot hold", int'(eval_slot), eslot);
      end
      do_eval(s);
    end
    chk("R4 ready low after slot 15", int'(eval_ready), 0);
    begin
      int cnt = 0;
      int exp_cyc = model_repl();
      eval_done = 1'b1;
      eval_score = 10'd1023;
      while (!eval_ready && cnt < 20) begin
        cnt++;
        @(negedge clk);
      end
      eval_done = 1'b0;
      chk("R4 stall length", cnt, exp_cyc);
    end
    chk("R3 done ignored while stalled", int'(eval_slot), 0);
    check_pool("R5 R6 R7 pool");
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) mused[i] = 0;
    for (int i = 0; i < 16; i++) begin
      moff[i] = (i < 8) ? 16 + (7 - i) : i - 8;
      msc[i] = 0;
      mused[moff[i]] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", int'(eval_ready), 1);
    chk("R1 slot", int'(eval_slot), 0);
    chk("R2 offset code -8", int'(eval_offset), 23);
    check_pool("R1 reset");
    run_round(0);
    run_round(2);
    run_round(1);
    for (int r = 0; r < 6; r++) run_round(2);
    begin
      bit dup = 0;
      for (int i = 0; i < 16; i++)
        for (int j = i + 1; j < 16; j++)
          if (pool_offsets[i*5 +: 5] == pool_offsets[j*5 +: 5]) dup = 1;
      chk("R8 distinct offsets", int'(dup), 0);
    end
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!ended) begin
      ended = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule